// File: doc/BRIEF.md
# Page-Table Address Translator with Reference Tracking

This block turns a 16-bit virtual address into a 16-bit physical address using a table of 64 page entries held inside the block. Pages are 1 KB. The low 10 bits of the address are the page offset, and the upper 6 bits select the entry. Each entry stores a valid flag, a referenced flag, a modified flag and a 6-bit frame number. When a request hits a valid entry, the block returns the frame number joined with the unchanged offset. When the entry is invalid, the block raises a fault instead.

The table is updated on each clock edge. A successful access marks its page as referenced, and a successful store also marks the page as modified. A sweep timer with a programmable period clears every referenced flag at once. A scanner always offers an eviction candidate: the lowest-numbered valid page whose referenced flag is clear. Entries are installed through a load port, and an inspection port reads any entry back.

Top module: `pgxlat_top`

## Requirements
- R1: On a request to a valid entry, `rsp_hit` is 1 and `rsp_paddr` is the entry's 6-bit frame number in bits 15:10 with the request's bits 9:0 in bits 9:0. The entry is selected by `req_vaddr[15:10]`. The outputs are combinational.
- R2: On a request to an invalid entry, `rsp_fault` is 1, `rsp_hit` is 0 and `rsp_paddr` is 0. With no request, both flags are 0.
- R3: A successful access sets the entry's referenced flag at the next clock edge. A faulting access changes no entry.
- R4: A successful access with `req_write`=1 also sets the modified flag. A read leaves the modified flag unchanged.
- R5: When `ld_en` is 1, the entry at `ld_vpn` takes `ld_valid` and `ld_pfn` at the next edge, with its referenced and modified flags cleared. A load overrides an access to the same entry in the same cycle.
- R6: With `sweep_period`=P>0, every referenced flag is cleared once every P cycles. After P is set with the timer idle, the clear lands on the P-th edge. P=0 disables clearing. A clear does not touch the valid flags, modified flags or frame numbers.
- R7: When a clear and a successful access fall in the same cycle, the accessed entry ends with its referenced flag set.
- R8: `victim_found` is 1 and `victim_vpn` names the lowest-numbered entry that is valid and has its referenced flag clear. If no entry qualifies, `victim_found` is 0.
- R9: After reset, every entry is invalid and all flags are clear, so every request faults and `victim_found` is 0.
- R10: `probe_valid`, `probe_ref`, `probe_dirty` and `probe_pfn` show the current stored state of entry `probe_vpn`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a store |
| req_vaddr | input | 16 | Virtual address |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Entry invalid: page fault |
| rsp_paddr | output | 16 | Physical address (0 unless hit) |
| ld_en | input | 1 | Install an entry |
| ld_vpn | input | 6 | Entry to install |
| ld_valid | input | 1 | Valid flag to install |
| ld_pfn | input | 6 | Frame number to install |
| sweep_period | input | 16 | Cycles between reference clears, 0 = off |
| probe_vpn | input | 6 | Entry to inspect |
| probe_valid | output | 1 | Inspected entry valid flag |
| probe_ref | output | 1 | Inspected entry referenced flag |
| probe_dirty | output | 1 | Inspected entry modified flag |
| probe_pfn | output | 6 | Inspected entry frame number |
| victim_found | output | 1 | An eviction candidate exists |
| victim_vpn | output | 6 | Lowest valid unreferenced entry |

## Verification
The bench targets four cases. A load and an access to the same entry in the same cycle: a design that lets the access win leaves a stale referenced or modified flag. A sweep in the same cycle as an access: a design that lets the clear win loses the reference just recorded. The exact edge on which a sweep lands, and the disabled setting: a design with an off-by-one timer clears one cycle early or late. The victim scan when several pages qualify and when none do: a design that scans in the wrong order names a higher page, and one that ignores the valid flag names an empty slot. Random traffic with no sweep active is checked every cycle against a reference model, covering translation, faults, flag updates and the victim.

// File: rtl/pgxlat_pkg.sv
package pgxlat_pkg;
    localparam int VA_W      = 16;
    localparam int OFF_W     = 10;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int PFN_W     = 6;
    localparam int PA_W      = PFN_W + OFF_W;
    localparam int NUM_PAGES = 1 << VPN_W;
    localparam int SWEEP_W   = 16;

    typedef struct packed {
        logic             valid;
        logic             refd;
        logic             dirty;
        logic [PFN_W-1:0] pfn;
    } pte_t;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    function automatic logic [PA_W-1:0] join_pa(logic [PFN_W-1:0] pfn,
                                                logic [OFF_W-1:0] off);
        return {pfn, off};
    endfunction
endpackage

// File: rtl/pgxlat_sweep.sv
module pgxlat_sweep
    import pgxlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SWEEP_W-1:0] period,
    output logic               pulse
);
    logic [SWEEP_W-1:0] cnt;

    always_comb pulse = (period != '0) && (cnt >= period - SWEEP_W'(1));

    always_ff @(posedge clk) begin
        if (rst || period == '0) cnt <= '0;
        else if (pulse)          cnt <= '0;
        else                     cnt <= cnt + SWEEP_W'(1);
    end

    // R6
    sweep_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && period > SWEEP_W'(1)) |=> (!pulse || period != $past(period)));
endmodule

// File: rtl/pgxlat_table.sv
module pgxlat_table
    import pgxlat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [VPN_W-1:0]     req_vpn,
    input  logic                 clr,
    input  logic                 ld_en,
    input  logic [VPN_W-1:0]     ld_vpn,
    input  logic                 ld_valid,
    input  logic [PFN_W-1:0]     ld_pfn,
    output pte_t                 tbl [NUM_PAGES],
    output logic [NUM_PAGES-1:0] valid_vec,
    output logic [NUM_PAGES-1:0] ref_vec
);
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ent
        logic touch;
        assign touch        = req_valid && req_vpn == VPN_W'(g) && tbl[g].valid;
        assign valid_vec[g] = tbl[g].valid;
        assign ref_vec[g]   = tbl[g].refd;

        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[g] <= '0;
            end else if (ld_en && ld_vpn == VPN_W'(g)) begin
                tbl[g] <= '{valid: ld_valid, refd: 1'b0, dirty: 1'b0, pfn: ld_pfn};
            end else begin
                if (clr)   tbl[g].refd <= 1'b0;
                if (touch) begin
                    tbl[g].refd <= 1'b1;
                    if (req_write) tbl[g].dirty <= 1'b1;
                end
            end
        end
    end

    // R3
    ref_set_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && tbl[req_vpn].valid && !(ld_en && ld_vpn == req_vpn))
        |=> tbl[$past(req_vpn)].refd);

    // R4
    dirty_set_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && tbl[req_vpn].valid && !(ld_en && ld_vpn == req_vpn))
        |=> tbl[$past(req_vpn)].dirty);

    // R5
    load_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (!tbl[$past(ld_vpn)].refd && !tbl[$past(ld_vpn)].dirty
                   && tbl[$past(ld_vpn)].pfn == $past(ld_pfn)));

    // R3
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> $stable(valid_vec));
endmodule

// File: rtl/pgxlat_victim.sv
module pgxlat_victim
    import pgxlat_pkg::*;
(
    input  logic [NUM_PAGES-1:0] valid_vec,
    input  logic [NUM_PAGES-1:0] ref_vec,
    output logic                 found,
    output logic [VPN_W-1:0]     vpn
);
    always_comb begin
        found = 1'b0;
        vpn   = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (valid_vec[i] && !ref_vec[i]) begin
                found = 1'b1;
                vpn   = VPN_W'(i);
            end
        end
    end
endmodule

// File: rtl/pgxlat_top.sv
module pgxlat_top
    import pgxlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               rsp_hit,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr,
    input  logic               ld_en,
    input  logic [VPN_W-1:0]   ld_vpn,
    input  logic               ld_valid,
    input  logic [PFN_W-1:0]   ld_pfn,
    input  logic [SWEEP_W-1:0] sweep_period,
    input  logic [VPN_W-1:0]   probe_vpn,
    output logic               probe_valid,
    output logic               probe_ref,
    output logic               probe_dirty,
    output logic [PFN_W-1:0]   probe_pfn,
    output logic               victim_found,
    output logic [VPN_W-1:0]   victim_vpn
);
    vaddr_t               va;
    pte_t                 tbl [NUM_PAGES];
    pte_t                 sel;
    pte_t                 prb;
    logic [NUM_PAGES-1:0] valid_vec;
    logic [NUM_PAGES-1:0] ref_vec;
    logic                 clr;

    assign va = vaddr_t'(req_vaddr);

    pgxlat_sweep u_sweep (
        .clk    (clk),
        .rst    (rst),
        .period (sweep_period),
        .pulse  (clr)
    );

    pgxlat_table u_table (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_vpn   (va.vpn),
        .clr       (clr),
        .ld_en     (ld_en),
        .ld_vpn    (ld_vpn),
        .ld_valid  (ld_valid),
        .ld_pfn    (ld_pfn),
        .tbl       (tbl),
        .valid_vec (valid_vec),
        .ref_vec   (ref_vec)
    );

    pgxlat_victim u_victim (
        .valid_vec (valid_vec),
        .ref_vec   (ref_vec),
        .found     (victim_found),
        .vpn       (victim_vpn)
    );

    always_comb begin
        sel       = tbl[va.vpn];
        prb       = tbl[probe_vpn];
        rsp_hit   = req_valid && sel.valid;
        rsp_fault = req_valid && !sel.valid;
        rsp_paddr = rsp_hit ? join_pa(sel.pfn, va.off) : '0;
        probe_valid = prb.valid;
        probe_ref   = prb.refd;
        probe_dirty = prb.dirty;
        probe_pfn   = prb.pfn;
    end

    // R8
    victim_ok_chk: assert property (@(posedge clk) disable iff (rst)
        victim_found |-> (valid_vec[victim_vpn] && !ref_vec[victim_vpn]));

    // R2
    fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_fault));
endmodule

// File: tb/pgxlat_top_tb_top.sv
`timescale 1ns/1ps
module pgxlat_top_tb_top;
    import pgxlat_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0;
    logic [15:0] req_vaddr = '0;
    logic rsp_hit, rsp_fault;
    logic [15:0] rsp_paddr;
    logic ld_en = 0, ld_valid = 0;
    logic [5:0] ld_vpn = '0, ld_pfn = '0;
    logic [15:0] sweep_period = '0;
    logic [5:0] probe_vpn = '0;
    logic probe_valid, probe_ref, probe_dirty;
    logic [5:0] probe_pfn;
    logic victim_found;
    logic [5:0] victim_vpn;

    int nchk = 0, nfail = 0;
    bit mv [64], mr [64], md [64];
    bit [5:0] mp [64];

    always #2.5 clk = ~clk;

    pgxlat_top dut_i (.*);

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_write = 0; ld_en = 0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; idle(); sweep_period = '0;
        tick(); tick();
        rst = 0;
        for (int i = 0; i < 64; i++) begin mv[i] = 0; mr[i] = 0; md[i] = 0; mp[i] = 0; end
    endtask

    task automatic load(input int vpn, input bit v, input int pfn);
        ld_en = 1; ld_vpn = 6'(vpn); ld_valid = v; ld_pfn = 6'(pfn);
        tick();
        ld_en = 0;
        mv[vpn] = v; mr[vpn] = 0; md[vpn] = 0; mp[vpn] = 6'(pfn);
    endtask

    task automatic access(input int vpn, input bit wr);
        req_valid = 1; req_write = wr; req_vaddr = {6'(vpn), 10'h0};
        tick();
        req_valid = 0; req_write = 0;
    endtask

    function automatic int exp_victim();
        for (int i = 0; i < 64; i++) if (mv[i] && !mr[i]) return i;
        return -1;
    endfunction

    task automatic probe(input int vpn, input bit er, input bit ed, input string rq);
        probe_vpn = 6'(vpn); #1;
        chk(probe_ref == er, rq, probe_ref, er);
        chk(probe_dirty == ed, rq, probe_dirty, ed);
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R9 reset state
        req_valid = 1; req_vaddr = 16'hA5A5; #1;
        chk(rsp_fault == 1 && rsp_hit == 0, "R9", rsp_fault, 1);
        chk(victim_found == 0, "R9", victim_found, 0);
        idle();

        load(3, 1, 5);
        load(9, 1, 6'h2A);
        // R1 translation
        req_valid = 1; req_vaddr = {6'd3, 10'h155}; #1;
        chk(rsp_hit && rsp_paddr == 16'h1555, "R1", rsp_paddr, 16'h1555);
        req_vaddr = {6'd9, 10'h3FF}; #1;
        chk(rsp_paddr == 16'hABFF, "R1", rsp_paddr, 16'hABFF);
        // R2 fault
        req_vaddr = {6'd4, 10'h001}; #1;
        chk(rsp_fault && !rsp_hit && rsp_paddr == 0, "R2", rsp_paddr, 0);
        idle();
        // R8 lowest candidate
        #1; chk(victim_found && victim_vpn == 3, "R8", victim_vpn, 3);
        // R3 faulting access changes nothing
        access(4, 1);
        probe_vpn = 4; #1;
        chk(probe_valid == 0 && probe_ref == 0 && probe_dirty == 0, "R3", probe_ref, 0);
        // R3/R4 read sets ref only
        access(3, 0);
        probe(3, 1, 0, "R4");
        chk(victim_vpn == 9, "R8", victim_vpn, 9);
        access(9, 1);
        probe(9, 1, 1, "R4");
        chk(victim_found == 0, "R8", victim_found, 0);
        // R6 sweep lands on P-th edge, dirty kept
        sweep_period = 16'd4;
        tick(); tick(); tick();
        probe(9, 1, 1, "R6");
        tick();
        probe(9, 0, 1, "R6");
        probe(3, 0, 0, "R6");
        sweep_period = 16'd0;
        probe_vpn = 9; #1;
        chk(probe_valid && probe_pfn == 6'h2A, "R6", probe_pfn, 6'h2A);
        chk(victim_found && victim_vpn == 3, "R8", victim_vpn, 3);
        // R6 disabled keeps refs
        access(3, 0);
        for (int i = 0; i < 12; i++) tick();
        probe(3, 1, 0, "R6");
        // R7 clear every cycle; access wins
        sweep_period = 16'd1;
        access(9, 0);
        probe(9, 1, 1, "R7");
        probe(3, 0, 0, "R7");
        tick();
        probe(9, 0, 1, "R7");
        sweep_period = 16'd0;
        // R5 load overrides same-cycle access
        access(3, 1);
        ld_en = 1; ld_vpn = 3; ld_valid = 1; ld_pfn = 6'h11;
        req_valid = 1; req_write = 1; req_vaddr = {6'd3, 10'h0};
        tick(); idle();
        probe(3, 0, 0, "R5");
        chk(probe_pfn == 6'h11, "R5", probe_pfn, 6'h11);

        // Random phase, sweep off
        do_reset();
        for (int i = 0; i < 64; i++) load(i, 1'($urandom % 4 != 0), int'($urandom % 64));
        for (int n = 0; n < 600; n++) begin
            int v, pv, lv;
            bit wr, ld, lval;
            int lpfn, vic;
            v = int'($urandom % 64); wr = 1'($urandom); pv = int'($urandom % 64);
            ld = ($urandom % 8) == 0;
            lv = (($urandom % 2) == 0) ? v : int'($urandom % 64);
            lval = 1'($urandom % 3 != 0); lpfn = int'($urandom % 64);
            req_valid = 1'($urandom % 4 != 0); req_write = wr;
            req_vaddr = {6'(v), 10'($urandom)};
            ld_en = ld; ld_vpn = 6'(lv); ld_valid = lval; ld_pfn = 6'(lpfn);
            probe_vpn = 6'(pv);
            #1;
            chk(rsp_hit == (req_valid && mv[v]), "R1", rsp_hit, req_valid && mv[v]);
            chk(rsp_fault == (req_valid && !mv[v]), "R2", rsp_fault, req_valid && !mv[v]);
            if (req_valid && mv[v])
                chk(rsp_paddr == {mp[v], req_vaddr[9:0]}, "R1", rsp_paddr, {mp[v], req_vaddr[9:0]});
            else
                chk(rsp_paddr == 0, "R2", rsp_paddr, 0);
            chk(probe_valid == mv[pv] && probe_ref == mr[pv] && probe_dirty == md[pv]
                && probe_pfn == mp[pv], "R10", probe_pfn, mp[pv]);
            vic = exp_victim();
            if (vic < 0) chk(victim_found == 0, "R8", victim_found, 0);
            else chk(victim_found && victim_vpn == 6'(vic), "R8", victim_vpn, vic);
            // model update for this edge
            if (ld) begin
                mv[lv] = lval; mr[lv] = 0; md[lv] = 0; mp[lv] = 6'(lpfn);
            end
            if (req_valid && mv[v] && !(ld && lv == v) && !(ld && lv != v && 0)) begin
                mr[v] = 1; if (wr) md[v] = 1;
            end
            tick();
        end
        idle();
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule